// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block gathers up to 32 interrupt lines and turns them into two requests for the processor: a high-priority request and a low-priority request. Software sets up three 32-bit registers through a small read/write port. The mask register chooses which lines may be recorded. The priority register marks which lines count as high priority. The status register holds the sticky record of lines that have fired. Lines 0 and 1 are recorded even when they are masked, but they never cause a request.

Every cycle the block compares the status register with the priority register and with the two enable bits from the processor status. A request is issued only when both enables are set. High priority wins over low priority. Any asserted line, masked or not, also clears the doze and sleep enables that the block passes through to the power manager. This lets a stimulus wake a sleeping core in the same cycle.

Top module: `tiered_irq_ctrl`

## Requirements
- R1: After reset, the mask, priority and status registers read 0, and both request outputs are 0.
- R2: Register select 0 is the mask, 1 is the priority and 2 is the status. Each is 32 bits wide and reads back exactly what was written, including bits 0 and 1. Select 3 reads 0, and a write to it changes no register.
- R3: A line at index 2 or above sets its status bit only while its mask bit is 1.
- R4: Lines 0 and 1 set their status bits whatever their mask bits are.
- R5: Status bits are sticky. Writing 0 to status clears them. If a line is asserted in the same cycle as that write, its status bit still ends up set.
- R6: Status and priority bits 0 and 1 take no part in the request decision.
- R7: No request is raised unless both the external-interrupt enable and the exception enable are 1.
- R8: A status bit that is also set in the priority register raises the high request. Otherwise any evaluated status bit raises the low request. The two requests are never high together.
- R9: Each request appears one clock after the status, priority or enable change that causes it, and drops one clock after its cause goes away.
- R10: In any cycle where at least one line is high, the doze and sleep enable outputs are 0, whether or not the line is masked. Otherwise they follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Interrupt lines, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 priority, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| cpu_ext_en | input | 1 | Processor external-interrupt enable |
| cpu_exc_en | input | 1 | Processor exception enable |
| doze_en_in | input | 1 | Doze enable from the power manager |
| sleep_en_in | input | 1 | Sleep enable from the power manager |
| doze_en_out | output | 1 | Doze enable after wake-up override |
| sleep_en_out | output | 1 | Sleep enable after wake-up override |
| req_hi | output | 1 | High-priority interrupt request (registered) |
| req_lo | output | 1 | Low-priority interrupt request (registered) |

## Verification
The table drives line patterns against different combinations of mask, priority and enables:
- A masked and an unmasked single line tell recording apart from discarding.
- A line that overlaps the priority register, beside one that does not, separates the high request from the low request. When both kinds fire together, the pattern shows that high wins.
- Patterns where only lines 0 and 1 overlap the priority register, or only those lines fire, show that the reserved bits are latched but have no effect on requests.
- Turning off either enable on its own shows that both enables are needed.

Directed tests then cover:
- the one-cycle request latency;
- a clear and a line assertion landing in the same cycle;
- the wake-up override with all lines masked.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_MASK = 2'd0,
        SEL_PRIO = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } req_t;

endpackage

// File: rtl/tic_line_gate.sv
// Chooses which asserted lines may set status: reserved lines always, the rest by mask.
module tic_line_gate #(
    parameter int NUM_LINES  = 32,
    parameter int RSVD_LINES = 2
) (
    input  logic [NUM_LINES-1:0] lines,
    input  logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] set_bits
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (i < RSVD_LINES) begin : g_rsvd
            assign set_bits[i] = lines[i];
        end else begin : g_masked
            assign set_bits[i] = lines[i] & mask[i];
        end
    end

endmodule

// File: rtl/tic_regs.sv
// Mask, priority and sticky status storage with the software port.
module tic_regs
    import tic_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  logic [NUM_LINES-1:0] wdata,
    input  logic [NUM_LINES-1:0] set_bits,
    output logic [NUM_LINES-1:0] rdata,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] prio_q,
    output logic [NUM_LINES-1:0] stat_q
);

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] prio;
        logic [NUM_LINES-1:0] stat;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (sel)
                SEL_MASK: regs_d.mask = wdata;
                SEL_PRIO: regs_d.prio = wdata;
                SEL_STAT: regs_d.stat = wdata;
                default:  ;
            endcase
        end
        // line hits are merged after the software write so a same-cycle hit survives a clear
        regs_d.stat = regs_d.stat | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (sel)
            SEL_MASK: rdata = regs_q.mask;
            SEL_PRIO: rdata = regs_q.prio;
            SEL_STAT: rdata = regs_q.stat;
            default:  rdata = '0;
        endcase
    end

    assign mask_q = regs_q.mask;
    assign prio_q = regs_q.prio;
    assign stat_q = regs_q.stat;

endmodule

// File: rtl/tic_arbiter.sv
// Registered two-level request decision.
module tic_arbiter
    import tic_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int RSVD_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] stat,
    input  logic [NUM_LINES-1:0] prio,
    input  logic                 ext_en,
    input  logic                 exc_en,
    output logic                 req_hi,
    output logic                 req_lo
);

    localparam logic [NUM_LINES-1:0] RSVD_MASK =
        {{(NUM_LINES-RSVD_LINES){1'b0}}, {RSVD_LINES{1'b1}}};

    logic [NUM_LINES-1:0] eval;
    logic                 gate_on;
    req_t                 req_d, req_q;

    always_comb begin
        eval     = stat & ~RSVD_MASK;
        gate_on  = ext_en & exc_en;
        req_d.hi = gate_on & (|(eval & prio));
        req_d.lo = gate_on & ~req_d.hi & (|eval);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req_hi = req_q.hi;
    assign req_lo = req_q.lo;

endmodule

// File: rtl/tic_wake.sv
// Any asserted line drops the doze and sleep enables in the same cycle.
module tic_wake #(
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_LINES-1:0] lines,
    input  logic                 doze_in,
    input  logic                 sleep_in,
    output logic                 doze_out,
    output logic                 sleep_out
);

    logic any_line;

    always_comb begin
        any_line  = |lines;
        doze_out  = doze_in & ~any_line;
        sleep_out = sleep_in & ~any_line;
    end

endmodule

// File: rtl/tiered_irq_ctrl.sv
module tiered_irq_ctrl
    import tic_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int RSVD_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_wr_en,
    input  logic [SEL_W-1:0]     reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    input  logic                 cpu_ext_en,
    input  logic                 cpu_exc_en,
    input  logic                 doze_en_in,
    input  logic                 sleep_en_in,
    output logic                 doze_en_out,
    output logic                 sleep_en_out,
    output logic                 req_hi,
    output logic                 req_lo
);

    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] prio_q;
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] set_bits;
    reg_sel_e             sel;

    assign sel = reg_sel_e'(reg_addr);

    tic_line_gate #(.NUM_LINES(NUM_LINES), .RSVD_LINES(RSVD_LINES)) u_gate (
        .lines    (irq_lines),
        .mask     (mask_q),
        .set_bits (set_bits)
    );

    tic_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .sel      (sel),
        .wdata    (reg_wdata),
        .set_bits (set_bits),
        .rdata    (reg_rdata),
        .mask_q   (mask_q),
        .prio_q   (prio_q),
        .stat_q   (status_q)
    );

    tic_arbiter #(.NUM_LINES(NUM_LINES), .RSVD_LINES(RSVD_LINES)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat   (status_q),
        .prio   (prio_q),
        .ext_en (cpu_ext_en),
        .exc_en (cpu_exc_en),
        .req_hi (req_hi),
        .req_lo (req_lo)
    );

    tic_wake #(.NUM_LINES(NUM_LINES)) u_wake (
        .lines     (irq_lines),
        .doze_in   (doze_en_in),
        .sleep_in  (sleep_en_in),
        .doze_out  (doze_en_out),
        .sleep_out (sleep_en_out)
    );

endmodule

// File: rtl/tiered_irq_ctrl_chk.sv
module tiered_irq_ctrl_chk #(
    parameter int NUM_LINES  = 32,
    parameter int RSVD_LINES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 reg_wr_en,
    input logic [1:0]           reg_addr,
    input logic                 cpu_ext_en,
    input logic                 cpu_exc_en,
    input logic                 doze_en_out,
    input logic                 sleep_en_out,
    input logic                 req_hi,
    input logic                 req_lo,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] prio_q
);

    localparam logic [NUM_LINES-1:0] KEEP =
        ~{{(NUM_LINES-RSVD_LINES){1'b0}}, {RSVD_LINES{1'b1}}};

    // R8
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_hi && req_lo));

    // R7
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(cpu_ext_en) && $past(cpu_exc_en)) |-> (!req_hi && !req_lo));

    // R6
    hi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_hi |-> $past(|(status_q & prio_q & KEEP)));

    // R6
    lo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_lo |-> $past(|(status_q & KEEP)));

    // R4
    rsvd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lines[RSVD_LINES-1:0]) |=>
        ((status_q[RSVD_LINES-1:0] & $past(irq_lines[RSVD_LINES-1:0]))
            == $past(irq_lines[RSVD_LINES-1:0])));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == 2'd2) |=>
        ((status_q & $past(status_q)) == $past(status_q)));

    // R10
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lines) |-> (!doze_en_out && !sleep_en_out));

endmodule

bind tiered_irq_ctrl tiered_irq_ctrl_chk #(
    .NUM_LINES(NUM_LINES), .RSVD_LINES(RSVD_LINES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_lines    (irq_lines),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .cpu_ext_en   (cpu_ext_en),
    .cpu_exc_en   (cpu_exc_en),
    .doze_en_out  (doze_en_out),
    .sleep_en_out (sleep_en_out),
    .req_hi       (req_hi),
    .req_lo       (req_lo),
    .status_q     (status_q),
    .prio_q       (prio_q)
);

// File: tb/tiered_irq_ctrl_tb.sv
module tiered_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] prio;
        logic [31:0] lines;
        logic [31:0] stat;
        logic        ext;
        logic        exc;
        logic        hi;
        logic        lo;
    } vec_t;

    // mask, prio, lines, expected status, ext, exc, expected hi, expected lo
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0010, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 masked
        '{32'h0000_0010, 32'h0000_0000, 32'h0000_0010, 32'h0000_0010, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 R8 low
        '{32'h0000_0010, 32'h0000_0010, 32'h0000_0010, 32'h0000_0010, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 high
        '{32'hFFFF_FFFF, 32'h0000_0100, 32'h0000_0110, 32'h0000_0110, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 precedence
        '{32'h0000_00F0, 32'h0000_000F, 32'h0000_00F3, 32'h0000_00F3, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 reserved prio
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0003, 32'h0000_0003, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 R6
        '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R7
        '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R7
        '{32'h8000_0000, 32'h0000_0000, 32'hC000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1}  // R3 R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_ext_en = 1'b0;
    logic        cpu_exc_en = 1'b0;
    logic        doze_en_in = 1'b0;
    logic        sleep_en_in = 1'b0;
    logic        doze_en_out;
    logic        sleep_en_out;
    logic        req_hi;
    logic        req_lo;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiered_irq_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_lines    (irq_lines),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cpu_ext_en   (cpu_ext_en),
        .cpu_exc_en   (cpu_exc_en),
        .doze_en_in   (doze_en_in),
        .sleep_en_in  (sleep_en_in),
        .doze_en_out  (doze_en_out),
        .sleep_en_out (sleep_en_out),
        .req_hi       (req_hi),
        .req_lo       (req_lo)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_reg(2'd0, rd); check("R1 mask", rd, 32'h0);
        read_reg(2'd1, rd); check("R1 prio", rd, 32'h0);
        read_reg(2'd2, rd); check("R1 status", rd, 32'h0);
        check("R1 req_hi", {31'b0, req_hi}, 32'h0);
        check("R1 req_lo", {31'b0, req_lo}, 32'h0);

        // R2 register port
        write_reg(2'd0, 32'hA5A5_5A5B);
        write_reg(2'd1, 32'h1234_5677);
        write_reg(2'd2, 32'h0F0F_0003);
        write_reg(2'd3, 32'hFFFF_FFFF);
        read_reg(2'd0, rd); check("R2 mask", rd, 32'hA5A5_5A5B);
        read_reg(2'd1, rd); check("R2 prio", rd, 32'h1234_5677);
        read_reg(2'd2, rd); check("R2 status", rd, 32'h0F0F_0003);
        read_reg(2'd3, rd); check("R2 unused select", rd, 32'h0);

        // table walk: R3 R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            cpu_ext_en = 1'b0;
            cpu_exc_en = 1'b0;
            write_reg(2'd0, VECS[v].mask);
            write_reg(2'd1, VECS[v].prio);
            write_reg(2'd2, 32'h0);
            irq_lines = VECS[v].lines;
            @(negedge clk);
            irq_lines  = '0;
            cpu_ext_en = VECS[v].ext;
            cpu_exc_en = VECS[v].exc;
            @(negedge clk);
            check($sformatf("R8 vec%0d hi", v), {31'b0, req_hi}, {31'b0, VECS[v].hi});
            check($sformatf("R8 vec%0d lo", v), {31'b0, req_lo}, {31'b0, VECS[v].lo});
            read_reg(2'd2, rd);
            check($sformatf("R3 vec%0d status", v), rd, VECS[v].stat);
        end

        // R9 latency of request rise and fall
        cpu_ext_en = 1'b0;
        cpu_exc_en = 1'b0;
        write_reg(2'd0, 32'h0000_0020);
        write_reg(2'd1, 32'h0);
        write_reg(2'd2, 32'h0);
        cpu_ext_en = 1'b1;
        cpu_exc_en = 1'b1;
        @(negedge clk);
        irq_lines = 32'h0000_0020;
        @(negedge clk);
        irq_lines = '0;
        check("R9 lo not yet", {31'b0, req_lo}, 32'h0);
        @(negedge clk);
        check("R9 lo raised", {31'b0, req_lo}, 32'h1);
        write_reg(2'd2, 32'h0);
        check("R9 lo held one cycle", {31'b0, req_lo}, 32'h1);
        @(negedge clk);
        check("R9 lo dropped", {31'b0, req_lo}, 32'h0);

        // R5 sticky and clear collision
        cpu_ext_en = 1'b0;
        cpu_exc_en = 1'b0;
        write_reg(2'd0, 32'h0000_0040);
        write_reg(2'd2, 32'h0000_0021);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = 2'd2;
        reg_wdata = 32'h0;
        irq_lines = 32'h0000_0040;
        @(negedge clk);
        reg_wr_en = 1'b0;
        irq_lines = '0;
        read_reg(2'd2, rd); check("R5 line wins over clear", rd, 32'h0000_0040);
        repeat (4) @(negedge clk);
        read_reg(2'd2, rd); check("R5 sticky", rd, 32'h0000_0040);
        write_reg(2'd2, 32'h0);
        read_reg(2'd2, rd); check("R5 cleared", rd, 32'h0);

        // R10 wake-up override with lines masked
        write_reg(2'd0, 32'h0);
        doze_en_in  = 1'b1;
        sleep_en_in = 1'b1;
        #1;
        check("R10 doze pass", {31'b0, doze_en_out}, 32'h1);
        check("R10 sleep pass", {31'b0, sleep_en_out}, 32'h1);
        irq_lines = 32'h0000_0100;
        #1;
        check("R10 doze cleared", {31'b0, doze_en_out}, 32'h0);
        check("R10 sleep cleared", {31'b0, sleep_en_out}, 32'h0);
        @(negedge clk);
        irq_lines = '0;
        #1;
        check("R10 doze restored", {31'b0, doze_en_out}, 32'h1);
        read_reg(2'd2, rd); check("R3 masked wake line not latched", rd, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule